// File: doc/BRIEF.md
# Shared Serial Port Pin Multiplexer

This block owns a small group of package pins that are shared between a queued SPI engine, two UART channels and general-purpose I/O. Three byte-wide registers on a simple register bus hold the pin configuration. The pin-owner register gives each SPI-capable pin either to the SPI engine or to GPIO. The pin-direction register sets each SPI-capable pin as an input or an output. The port-latch register holds the GPIO output values. For every pin, the block computes the pad output value and the output enable, and it routes the pad input to the peripheral that owns the pin.

The two classes of pin follow different rules. SPI-capable pins are switched by the pin-owner register, and they obey the pin-direction register in both modes. UART pins ignore both of those registers. A transmit pin is always an output, and a receive pin is always an input. A UART pin belongs to its UART only while that UART's transmitter or receiver is enabled. Otherwise it acts as a discrete GPIO pin.

A read of the port-latch offsets returns the pin levels, not the latched values. The levels pass through a two-flop synchronizer first. A twelfth pin is a dedicated external clock input and is only forwarded to the serial engines. Software is expected to write the latch before it turns a pin into an output, so the pin never drives an undefined level.

Top module: `serial_pin_mux`

## Requirements
- R1: After reset, the latch, pin-owner and pin-direction registers are all zero. Every SPI-capable pin is therefore a GPIO input with its output enable low. Both transmit pads drive 0.
- R2: Pin-owner register (offset 0x16, bits 6:0, one bit per SPI pin, bit 7 reads 0). A bit of 0 drives the pad from the latch bit. A bit of 1 drives the pad from the SPI engine output.
- R3: Pin-direction register (offset 0x17, bits 6:0, bit 7 reads 0). Each bit sets the output enable of its SPI pin: 1 is an output, 0 is an input. This holds in both GPIO mode and SPI mode.
- R4: The latch register accepts and holds a write while its pin is still an input. The value is driven once the direction bit is later set.
- R5: A transmit pad carries the UART transmit data while that transmitter is enabled and carries its latch bit otherwise. The pin-owner and pin-direction registers do not affect it.
- R6: While its receiver is enabled, a receive channel gets its pad level. While the receiver is disabled, the channel sees a constant 1 (line idle).
- R7: Latch readback: offset 0x15 gives bits 7:0 and offset 0x14 gives bits 10:8, with the upper bits reading 0. Bit order is SPI pins 0..6, then TX0, TX1, RX0, RX1. The value read is the pin levels through a two-flop synchronizer, so a pad change shows after exactly two rising clock edges. Writes to the RX bits are ignored.
- R8: The SPI engine input of a pin equals the pad level when the pin is owned by the SPI engine, and 0 when it is GPIO.
- R9: Offsets other than 0x14 to 0x17 read as 0, and writes to them change no register.
- R10: The external clock input is forwarded unchanged to the clock output for the serial engines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and synchronizer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Byte offset in the register space |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| ext_clk_i | input | 1 | Dedicated external clock pin |
| ext_clk_o | output | 1 | External clock forwarded to the serial engines |
| spi_pad_i | input | 7 | Pad levels of the SPI-capable pins |
| spi_pad_o | output | 7 | Pad output values of the SPI-capable pins |
| spi_pad_oe_o | output | 7 | Pad output enables of the SPI-capable pins |
| spi_eng_out_i | input | 7 | Output values from the SPI engine |
| spi_eng_in_o | output | 7 | Pad levels routed to the SPI engine |
| tx_pad_o | output | 2 | Transmit pads (always outputs) |
| rx_pad_i | input | 2 | Receive pads (always inputs) |
| uart_tx_en_i | input | 2 | Per-channel transmitter enable |
| uart_tx_data_i | input | 2 | Per-channel serial transmit data |
| uart_rx_en_i | input | 2 | Per-channel receiver enable |
| uart_rx_data_o | output | 2 | Per-channel receive data to the UARTs |

## Verification
The bench first checks preloading. It writes the latch while the pin is still an input, and confirms that the pad stays undriven and that readback shows the external level, not the latch. A design that stored only output pins, or that read back the latch, would fail at that point. The bench then writes all ones to the pin-owner and pin-direction registers and confirms that the UART pads do not move. A mux that decoded the UART pins through those registers would change the transmit pins there. The bench also counts the synchronizer delay edge by edge, so a readback path with one stage or three stages shows up. Random rounds mix owner, direction, enable and pad patterns with unmapped-offset writes, which catches wrong bit positions and wrong address decode.

// File: rtl/pin_mux_pkg.sv
package pin_mux_pkg;
  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;
  // register byte offsets
  localparam logic [ADDR_W-1:0] OFS_LAT_HI = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_LAT_LO = 5'h15;
  localparam logic [ADDR_W-1:0] OFS_OWNER  = 5'h16;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 5'h17;
endpackage

// File: rtl/pmx_sync.sv
module pmx_sync #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  // counts edges since reset so the delay check never looks before it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               warm_q <= '0;
    else if (warm_q != 2'd2)   warm_q <= warm_q + 2'd1;
  end

  assign q_o = s2_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R7
endmodule

// File: rtl/pmx_regs.sv
module pmx_regs
  import pin_mux_pkg::*;
#(
  parameter int N_SPI  = 7,
  parameter int LAT_W  = 9,
  parameter int PORT_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [PORT_W-1:0] pin_lvl_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [LAT_W-1:0]  latch_o,
  output logic [N_SPI-1:0]  owner_o,
  output logic [N_SPI-1:0]  dir_o
);
  localparam int HI_LAT = LAT_W - BYTE_W;

  logic [LAT_W-1:0] latch_q;
  logic [N_SPI-1:0] owner_q, dir_q;
  logic wr_hi, wr_lo, wr_own, wr_dir;

  assign wr_hi  = we_i && (addr_i == OFS_LAT_HI);
  assign wr_lo  = we_i && (addr_i == OFS_LAT_LO);
  assign wr_own = we_i && (addr_i == OFS_OWNER);
  assign wr_dir = we_i && (addr_i == OFS_DIR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      owner_q <= '0;
      dir_q   <= '0;
    end else begin
      if (wr_lo)  latch_q[BYTE_W-1:0]     <= wdata_i;
      if (wr_hi)  latch_q[LAT_W-1:BYTE_W] <= wdata_i[HI_LAT-1:0];
      if (wr_own) owner_q                 <= wdata_i[N_SPI-1:0];
      if (wr_dir) dir_q                   <= wdata_i[N_SPI-1:0];
    end
  end

  // latch reads return synchronized pin levels, not the stored bits
  always_comb begin
    unique case (addr_i)
      OFS_LAT_HI: rdata_o = BYTE_W'(pin_lvl_i[PORT_W-1:BYTE_W]);
      OFS_LAT_LO: rdata_o = pin_lvl_i[BYTE_W-1:0];
      OFS_OWNER:  rdata_o = BYTE_W'(owner_q);
      OFS_DIR:    rdata_o = BYTE_W'(dir_q);
      default:    rdata_o = '0;
    endcase
  end

  assign latch_o = latch_q;
  assign owner_o = owner_q;
  assign dir_o   = dir_q;

  AST_OWNER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_own |=> (owner_q == $past(wdata_i[N_SPI-1:0]))); // R2
  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> (dir_q == $past(wdata_i[N_SPI-1:0]))); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_hi || wr_lo) |=> $stable(latch_q)); // R4
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_own || wr_dir) |=> ($stable(owner_q) && $stable(dir_q))); // R9
endmodule

// File: rtl/pmx_spi_pin.sv
module pmx_spi_pin (
  input  logic owner_i,
  input  logic dir_i,
  input  logic latch_i,
  input  logic eng_out_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic eng_in_o
);
  assign pad_o    = owner_i ? eng_out_i : latch_i;
  assign pad_oe_o = dir_i;  // direction applies in both modes
  assign eng_in_o = owner_i & pad_i;
endmodule

// File: rtl/pmx_uart_ch.sv
module pmx_uart_ch (
  input  logic tx_en_i,
  input  logic tx_data_i,
  input  logic tx_latch_i,
  output logic tx_pad_o,
  input  logic rx_en_i,
  input  logic rx_pad_i,
  output logic rx_data_o
);
  assign tx_pad_o  = tx_en_i ? tx_data_i : tx_latch_i;
  assign rx_data_o = rx_en_i ? rx_pad_i : 1'b1;  // idle line when disabled
endmodule

// File: rtl/serial_pin_mux.sv
module serial_pin_mux
  import pin_mux_pkg::*;
#(
  parameter int N_SPI  = 7,
  parameter int N_UART = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  input  logic              ext_clk_i,
  output logic              ext_clk_o,
  input  logic [N_SPI-1:0]  spi_pad_i,
  output logic [N_SPI-1:0]  spi_pad_o,
  output logic [N_SPI-1:0]  spi_pad_oe_o,
  input  logic [N_SPI-1:0]  spi_eng_out_i,
  output logic [N_SPI-1:0]  spi_eng_in_o,
  output logic [N_UART-1:0] tx_pad_o,
  input  logic [N_UART-1:0] rx_pad_i,
  input  logic [N_UART-1:0] uart_tx_en_i,
  input  logic [N_UART-1:0] uart_tx_data_i,
  input  logic [N_UART-1:0] uart_rx_en_i,
  output logic [N_UART-1:0] uart_rx_data_o
);
  localparam int LAT_W  = N_SPI + N_UART;
  localparam int PORT_W = N_SPI + 2 * N_UART;

  logic [LAT_W-1:0]  latch;
  logic [N_SPI-1:0]  owner, dir;
  logic [PORT_W-1:0] pin_lvl, pin_sync;

  pmx_regs #(.N_SPI(N_SPI), .LAT_W(LAT_W), .PORT_W(PORT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .pin_lvl_i (pin_sync),
    .rdata_o   (reg_rdata_o),
    .latch_o   (latch),
    .owner_o   (owner),
    .dir_o     (dir)
  );

  for (genvar k = 0; k < N_SPI; k++) begin : g_spi
    pmx_spi_pin u_pin (
      .owner_i   (owner[k]),
      .dir_i     (dir[k]),
      .latch_i   (latch[k]),
      .eng_out_i (spi_eng_out_i[k]),
      .pad_i     (spi_pad_i[k]),
      .pad_o     (spi_pad_o[k]),
      .pad_oe_o  (spi_pad_oe_o[k]),
      .eng_in_o  (spi_eng_in_o[k])
    );

    AST_SPI_IN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !owner[k] |-> (spi_eng_in_o[k] == 1'b0)); // R8
  end

  for (genvar j = 0; j < N_UART; j++) begin : g_uart
    pmx_uart_ch u_ch (
      .tx_en_i    (uart_tx_en_i[j]),
      .tx_data_i  (uart_tx_data_i[j]),
      .tx_latch_i (latch[N_SPI+j]),
      .tx_pad_o   (tx_pad_o[j]),
      .rx_en_i    (uart_rx_en_i[j]),
      .rx_pad_i   (rx_pad_i[j]),
      .rx_data_o  (uart_rx_data_o[j])
    );

    AST_RX_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !uart_rx_en_i[j] |-> uart_rx_data_o[j]); // R6
  end

  // readback order: SPI pins, TX pins, RX pins
  assign pin_lvl = {rx_pad_i, tx_pad_o, spi_pad_i};

  pmx_sync #(.W(PORT_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_lvl),
    .q_o    (pin_sync)
  );

  assign ext_clk_o = ext_clk_i;
endmodule

// File: tb/serial_pin_mux_bench.sv
`timescale 1ns/1ps
module serial_pin_mux_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_clk = 1'b0, ext_clk_fwd;
  logic [6:0] spi_pad_in, spi_pad_out, spi_oe, spi_eng_out = '0, spi_eng_in;
  logic [6:0] ext_drv = '0;
  logic [1:0] tx_pad, rx_pad = 2'b11, tx_en = '0, tx_data = '0, rx_en = '0, rx_data;
  int n_run = 0, n_fail = 0;

  // m_ = bench model of register contents
  logic [8:0] m_lat = '0;
  logic [6:0] m_own = '0, m_dir = '0;

  always #2 clk = ~clk;

  // pad resolution: driven level when enabled, external level otherwise
  assign spi_pad_in = (spi_oe & spi_pad_out) | (~spi_oe & ext_drv);

  serial_pin_mux u_serial_pin_mux (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .ext_clk_i(ext_clk), .ext_clk_o(ext_clk_fwd),
    .spi_pad_i(spi_pad_in), .spi_pad_o(spi_pad_out), .spi_pad_oe_o(spi_oe),
    .spi_eng_out_i(spi_eng_out), .spi_eng_in_o(spi_eng_in),
    .tx_pad_o(tx_pad), .rx_pad_i(rx_pad),
    .uart_tx_en_i(tx_en), .uart_tx_data_i(tx_data),
    .uart_rx_en_i(rx_en), .uart_rx_data_o(rx_data)
  );

  function automatic logic [6:0] exp_spi_out();
    return (m_own & spi_eng_out) | (~m_own & m_lat[6:0]);
  endfunction
  function automatic logic [6:0] exp_spi_lvl();
    return (m_dir & exp_spi_out()) | (~m_dir & ext_drv);
  endfunction
  function automatic logic [1:0] exp_tx();
    return (tx_en & tx_data) | (~tx_en & m_lat[8:7]);
  endfunction
  function automatic logic [1:0] exp_rx();
    return (rx_en & rx_pad) | ~rx_en;
  endfunction
  function automatic logic [10:0] exp_lvl();
    return {rx_pad, exp_tx(), exp_spi_lvl()};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      5'h14: m_lat[8] = d[0];
      5'h15: m_lat[7:0] = d;
      5'h16: m_own = d[6:0];
      5'h17: m_dir = d[6:0];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic chk_pins(input string tag);
    #1;
    chk({tag, " R2 spi pad"}, 16'(spi_pad_out), 16'(exp_spi_out()));
    chk({tag, " R3 spi oe"}, 16'(spi_oe), 16'(m_dir));
    chk({tag, " R8 eng in"}, 16'(spi_eng_in), 16'(m_own & exp_spi_lvl()));
    chk({tag, " R5 tx pad"}, 16'(tx_pad), 16'(exp_tx()));
    chk({tag, " R6 rx data"}, 16'(rx_data), 16'(exp_rx()));
  endtask

  task automatic chk_readback(input string tag);
    logic [7:0] lo, hi;
    repeat (3) @(negedge clk);
    rd(5'h15, lo);
    rd(5'h14, hi);
    chk({tag, " R7 readback"}, {hi, lo}, 16'(exp_lvl()));
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h16, d); chk("R1 owner reset", 16'(d), 16'h0);
    rd(5'h17, d); chk("R1 dir reset", 16'(d), 16'h0);
    chk("R1 oe reset", 16'(spi_oe), 16'h0);
    chk("R1 tx reset", 16'(tx_pad), 16'h0);
    chk_pins("R1");

    // R4 preload while input, then enable output
    ext_drv = 7'h2a;
    wr(5'h15, 8'h55);
    chk_pins("R4 preload");
    chk_readback("R4 preload");
    wr(5'h17, 8'h7f);
    chk_pins("R4 enable");
    chk("R4 driven latch", 16'(spi_pad_out), 16'h55);
    chk_readback("R4 enable");

    // R7 synchronizer: exactly two edges
    wr(5'h17, 8'h00);
    ext_drv = 7'h00;
    repeat (3) @(negedge clk);
    ext_drv = 7'h01;
    @(negedge clk); rd(5'h15, d); chk("R7 one edge", 16'(d[0]), 16'h0);
    @(negedge clk); rd(5'h15, d); chk("R7 two edges", 16'(d[0]), 16'h1);

    // R7 RX bits not writable, upper bits zero
    rx_pad = 2'b00;
    wr(5'h14, 8'hff);
    chk_readback("R7 rx write ignored");
    rd(5'h14, d); chk("R7 hi upper zero", 16'(d[7:5]), 16'h0);

    // R5 owner/dir all ones leave UART pins untouched
    wr(5'h15, 8'h00); wr(5'h14, 8'h01);
    wr(5'h16, 8'hff); wr(5'h17, 8'hff);
    chk("R5 tx ignores owner/dir", 16'(tx_pad), 16'b10);
    rd(5'h16, d); chk("R2 owner bit7 zero", 16'(d), 16'h7f);
    rd(5'h17, d); chk("R3 dir bit7 zero", 16'(d), 16'h7f);
    chk_pins("R5");

    // R9 unmapped offsets
    wr(5'h10, 8'h00); wr(5'h18, 8'h00); wr(5'h1f, 8'h00);
    rd(5'h16, d); chk("R9 owner unchanged", 16'(d), 16'h7f);
    rd(5'h17, d); chk("R9 dir unchanged", 16'(d), 16'h7f);
    rd(5'h00, d); chk("R9 unmapped read", 16'(d), 16'h0);
    rd(5'h18, d); chk("R9 unmapped read hi", 16'(d), 16'h0);

    // R10 external clock forwarding
    ext_clk = 1'b1; #1 chk("R10 ext clk high", 16'(ext_clk_fwd), 16'h1);
    ext_clk = 1'b0; #1 chk("R10 ext clk low", 16'(ext_clk_fwd), 16'h0);

    // random rounds
    for (int i = 0; i < 200; i++) begin
      spi_eng_out = 7'($urandom);
      ext_drv     = 7'($urandom);
      tx_en       = 2'($urandom);
      tx_data     = 2'($urandom);
      rx_en       = 2'($urandom);
      rx_pad      = 2'($urandom);
      if ($urandom % 4 == 0) wr(5'($urandom), 8'($urandom));
      wr(5'h16, 8'($urandom));
      wr(5'h17, 8'($urandom));
      wr(5'h15, 8'($urandom));
      wr(5'h14, 8'($urandom));
      chk_pins("rand");
      chk_readback("rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule